// File: doc/BRIEF.md
# Interrupt Distributor Register Core

This block holds the per-source state of a small multiprocessor interrupt controller and exposes it through a plain 32-bit register bus. The sources come in groups of 32. Each source carries an enable flag, a pending flag, an active flag, an 8-bit priority, a CPU target mask and a 2-bit sensing and model field. The CPU interfaces consume two vectors from the block. The first is the enable state. The second is the set of sources that are pending, enabled and allowed through by the global on switch.

Raw peripheral lines drive the pending flags. Each source senses either a rising edge or a high level, as its configuration selects. Software can also set or clear pending flags, and it can set or clear enable flags, through separate write-one banks, so no read-modify-write is ever needed. IDs 0 to 15 are software interrupts and have no hardware line. IDs 16 to 31 are per-CPU private lines. Shared lines start at ID 32.

A CPU interface reports that it has taken an interrupt by pulsing an acknowledge with the ID. It later retires the interrupt with an end-of-service pulse. The register bus reads combinationally in the cycle the address is presented. A write takes effect at the clock edge where `wr_en` is high.

Top module: `irq_dist_core`

## Requirements
- R1: Offset 0x000 is the global control word. Bit 0 is readable and writable and turns forwarding on. Every other bit reads 0. It resets to 0.
- R2: Offset 0x004 is read-only. Bits 4:0 read NGRP-1 and bits 7:5 read NCPU-1. All other bits read 0, including bits 15:11, which hold the lockable-interrupt count of zero. Writes to this word change nothing.
- R3: At offset 0x100+4g, a 1 in bit b of a written word sets the enable of ID 32g+b. At 0x180+4g, a 1 clears it. A 0 bit leaves that enable unchanged. Both words read back the enable state, and `en_out` mirrors it.
- R4: At 0x200+4g, a 1 in bit b sets the pending flag of ID 32g+b. At 0x280+4g, a 1 clears it. Both words read the pending state. A clear wins over a hardware set that arrives in the same cycle.
- R5: When bit 1 of a source's configuration field is 1, a rising edge on its `irq_in` line makes it pending. It stays pending after the line falls, until it is cleared.
- R6: When bit 1 is 0, the source becomes pending in every cycle its line is high. After a clear it is pending again one cycle later if the line is still high. It stays cleared if the line is low.
- R7: IDs 0 to 15 ignore `irq_in`. Their configuration fields read 2'b10 and ignore writes. They become pending only through the pending-set word.
- R8: Byte k of the word at 0x400+4w is the priority of ID 4w+k, 8 bits, read and write. Byte k at 0x800+4w is the target mask of ID 4w+k. Only its low NCPU bits are stored, and the rest read 0.
- R9: Bits 2k+1:2k of the word at 0xC00+4w are the field of ID 16w+k. Bit 1 selects edge sensing. Bit 0 selects the model where the first accepting CPU claims the interrupt. For IDs 16 and up, the field is stored and read back as written, and it resets to 0.
- R10: An `ack_valid` pulse with `ack_id` sets that source's active flag and clears its pending flag. An `eoi_valid` pulse with `eoi_id` clears the active flag. Active state reads at 0x300+4g, and writes there change nothing.
- R11: `pend_out` bit i is 1 only when ID i is pending, its enable is set and control bit 0 is 1.
- R12: The following read 0, and writes to them change nothing: offsets outside the listed words, group or word indices beyond the implemented sources, and addresses with bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_in | input | 32*NGRP | Raw interrupt lines, one per ID |
| ack_valid | input | 1 | A CPU has taken interrupt `ack_id` |
| ack_id | input | clog2(32*NGRP) | ID being acknowledged |
| eoi_valid | input | 1 | A CPU has finished interrupt `eoi_id` |
| eoi_id | input | clog2(32*NGRP) | ID being retired |
| pend_out | output | 32*NGRP | Pending, enabled and forwarded sources |
| en_out | output | 32*NGRP | Enable state per source |

## Verification
The bench builds the block with NGRP=2 and NCPU=4, which gives 64 sources. The second group therefore exercises the mapping of group index to bit position in the enable, pending and active words. A group index of 2, together with the priority, target and configuration words just past ID 63, serves as an unimplemented address. With four CPUs, the target mask is narrower than its byte, so truncation on write shows up in the read-back. The type word reads a distinct non-zero value in both of its fields.

// File: rtl/irq_dist_core.sv
module irq_dist_core #(
  parameter int NGRP = 2,
  parameter int NCPU = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [11:0]                   addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  input  logic [32*NGRP-1:0]            irq_in,
  input  logic                          ack_valid,
  input  logic [$clog2(32*NGRP)-1:0]    ack_id,
  input  logic                          eoi_valid,
  input  logic [$clog2(32*NGRP)-1:0]    eoi_id,
  output logic [32*NGRP-1:0]            pend_out,
  output logic [32*NGRP-1:0]            en_out
);
  localparam int NSRC = 32 * NGRP;
  localparam logic [31:0] TYPE_W = 32'(NGRP - 1) | (32'(NCPU - 1) << 5);

  logic            ctrl_en;
  logic [NSRC-1:0] en, pend, act, irq_q;
  logic [7:0]      prio [NSRC];
  logic [NCPU-1:0] tgt  [NSRC];
  logic [1:0]      cfg  [NSRC];

  logic [NSRC-1:0] en_set, en_clr, sw_set, sw_clr, hw_set, ack_hit, eoi_hit;

  wire       aligned = addr[1:0] == 2'b00;
  wire [4:0] blk     = addr[11:7];
  wire [4:0] gsel    = addr[6:2];
  wire [7:0] bsel    = addr[9:2];
  wire [5:0] csel    = addr[7:2];
  wire       wr_ok   = wr_en && aligned;
  wire       w_ctrl  = wr_ok && addr[11:2] == 10'd0;
  wire       w_pri   = wr_ok && addr[11:10] == 2'b01;
  wire       w_tgt   = wr_ok && addr[11:10] == 2'b10;
  wire       w_cfg   = wr_ok && addr[11:8] == 4'hC;
  wire [NSRC-1:0] rise = irq_in & ~irq_q;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      logic hit;
      hit        = wr_ok && gsel == 5'(i / 32) && wdata[i % 32];
      en_set[i]  = hit && blk == 5'd2;
      en_clr[i]  = hit && blk == 5'd3;
      sw_set[i]  = hit && blk == 5'd4;
      sw_clr[i]  = hit && blk == 5'd5;
      hw_set[i]  = (i >= 16) && (cfg[i][1] ? rise[i] : irq_in[i]);
      ack_hit[i] = ack_valid && int'(ack_id) == i;
      eoi_hit[i] = eoi_valid && int'(eoi_id) == i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      en      <= '0;
      pend    <= '0;
      act     <= '0;
      irq_q   <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0;
        tgt[i]  <= '0;
        cfg[i]  <= (i < 16) ? 2'b10 : 2'b00;
      end
    end else begin
      if (w_ctrl) ctrl_en <= wdata[0];
      irq_q <= irq_in;
      en    <= (en | en_set) & ~en_clr;
      pend  <= (pend | hw_set | sw_set) & ~(sw_clr | ack_hit);
      act   <= (act & ~eoi_hit) | ack_hit;
      for (int i = 0; i < NSRC; i++) begin
        if (w_pri && bsel == 8'(i / 4)) prio[i] <= wdata[8*(i%4) +: 8];
        if (w_tgt && bsel == 8'(i / 4)) tgt[i]  <= wdata[8*(i%4) +: NCPU];
        if (w_cfg && csel == 6'(i / 16) && i >= 16) cfg[i] <= wdata[2*(i%16) +: 2];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (addr[11:2] == 10'd0) rdata[0] = ctrl_en;
      else if (addr[11:2] == 10'd1) rdata = TYPE_W;
      for (int i = 0; i < NSRC; i++) begin
        if (gsel == 5'(i / 32)) begin
          case (blk)
            5'd2, 5'd3: rdata[i % 32] = en[i];
            5'd4, 5'd5: rdata[i % 32] = pend[i];
            5'd6:       rdata[i % 32] = act[i];
            default: ;
          endcase
        end
        if (addr[11:10] == 2'b01 && bsel == 8'(i / 4)) rdata[8*(i%4) +: 8]    = prio[i];
        if (addr[11:10] == 2'b10 && bsel == 8'(i / 4)) rdata[8*(i%4) +: NCPU] = tgt[i];
        if (addr[11:8] == 4'hC && csel == 6'(i / 16))  rdata[2*(i%16) +: 2]   = cfg[i];
      end
    end
  end

  assign pend_out = pend & en & {NSRC{ctrl_en}};
  assign en_out   = en;

  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_out) |-> ctrl_en);

  a_r3_enset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h100 && wdata[0]) |=> en_out[0]);

  a_r4_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h280 && wdata[0]) |=> (rdata[0] == 1'b0 || addr != 12'h200) && !pend[0]);

  a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_in[16]) && cfg[16][1] && !(wr_en && addr == 12'h280 && wdata[16]) &&
     !(ack_valid && int'(ack_id) == 16)) |=> pend[16]);

  a_r10_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && int'(ack_id) < NSRC) |=> act[$past(ack_id)]);
endmodule

// File: tb/tb_irq_dist_core.sv
`timescale 1ns/1ps
module tb_irq_dist_core;
  localparam int NGRP = 2;
  localparam int NCPU = 4;
  localparam int NSRC = 32 * NGRP;
  localparam int IDW  = $clog2(NSRC);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NSRC-1:0] irq_in = '0;
  logic            ack_valid = 1'b0;
  logic [IDW-1:0]  ack_id = '0;
  logic            eoi_valid = 1'b0;
  logic [IDW-1:0]  eoi_id = '0;
  logic [NSRC-1:0] pend_out, en_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_dist_core #(.NGRP(NGRP), .NCPU(NCPU)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_in(irq_in), .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id), .pend_out(pend_out), .en_out(en_out));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd32(12'h000, d); chk("R1 ctrl reset", 64'(d), 64'h0);
    rd32(12'h100, d); chk("R3 enable reset", 64'(d), 64'h0);
    chk("R11 pend_out reset", 64'(pend_out), 64'h0);
  endtask

  task automatic t_ctrl_type;
    logic [31:0] d;
    wr32(12'h000, 32'hFFFF_FFFF);
    rd32(12'h000, d); chk("R1 ctrl bit0 only", 64'(d), 64'h1);
    wr32(12'h000, 32'h0);
    rd32(12'h004, d); chk("R2 type word", 64'(d), 64'h61);
    wr32(12'h004, 32'hFFFF_FFFF);
    rd32(12'h004, d); chk("R2 type read-only", 64'(d), 64'h61);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr32(12'h104, 32'h8000_0005);
    rd32(12'h104, d); chk("R3 set group1", 64'(d), 64'h8000_0005);
    rd32(12'h184, d); chk("R3 clear bank reads state", 64'(d), 64'h8000_0005);
    wr32(12'h184, 32'h0000_0004);
    rd32(12'h104, d); chk("R3 clear one bit", 64'(d), 64'h8000_0001);
    chk("R3 en_out mirror", 64'(en_out), {32'h8000_0001, 32'h0});
    wr32(12'h104, 32'h0);
    rd32(12'h104, d); chk("R3 zero bits no effect", 64'(d), 64'h8000_0001);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr32(12'hC08, 32'h0000_0002);
    @(negedge clk); irq_in[32] = 1'b1;
    @(negedge clk); irq_in[32] = 1'b0;
    idle(2);
    rd32(12'h204, d); chk("R5 edge latched after fall", 64'(d[0]), 64'h1);
    wr32(12'h284, 32'h1);
    rd32(12'h204, d); chk("R4 pending clear", 64'(d[0]), 64'h0);
    rd32(12'h284, d); chk("R4 clear bank reads state", 64'(d[0]), 64'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); irq_in[33] = 1'b1;
    @(negedge clk);
    rd32(12'h204, d); chk("R6 level pending", 64'(d[1]), 64'h1);
    wr32(12'h284, 32'h2);
    rd32(12'h204, d); chk("R4 clear wins over level", 64'(d[1]), 64'h0);
    @(negedge clk);
    rd32(12'h204, d); chk("R6 level reasserts", 64'(d[1]), 64'h1);
    irq_in[33] = 1'b0;
    wr32(12'h284, 32'h2);
    idle(2);
    rd32(12'h204, d); chk("R6 stays cleared when low", 64'(d[1]), 64'h0);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    @(negedge clk); irq_in[5] = 1'b1;
    idle(3);
    rd32(12'h200, d); chk("R7 line ignored", 64'(d), 64'h0);
    irq_in[5] = 1'b0;
    wr32(12'hC00, 32'h0);
    rd32(12'hC00, d); chk("R7 config fixed", 64'(d), 64'hAAAA_AAAA);
    wr32(12'h200, 32'h0000_0020);
    rd32(12'h200, d); chk("R7 software set", 64'(d), 64'h20);
    wr32(12'h280, 32'h0000_0020);
  endtask

  task automatic t_prio_tgt_cfg;
    logic [31:0] d;
    wr32(12'h404, 32'h4433_2211);
    rd32(12'h404, d); chk("R8 priority bytes", 64'(d), 64'h4433_2211);
    wr32(12'h804, 32'hFFFF_FFFF);
    rd32(12'h804, d); chk("R8 target truncation", 64'(d), 64'h0F0F_0F0F);
    wr32(12'hC0C, 32'hDEAD_BEEF);
    rd32(12'hC0C, d); chk("R9 config readback", 64'(d), 64'hDEAD_BEEF);
    wr32(12'hC04, 32'h0000_0001);
    rd32(12'hC04, d); chk("R9 model bit stored", 64'(d), 64'h1);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr32(12'h204, 32'h0000_0100);
    @(negedge clk); ack_valid = 1'b1; ack_id = IDW'(40);
    @(negedge clk); ack_valid = 1'b0;
    rd32(12'h304, d); chk("R10 active set", 64'(d), 64'h100);
    rd32(12'h204, d); chk("R10 ack clears pending", 64'(d[8]), 64'h0);
    @(negedge clk); eoi_valid = 1'b1; eoi_id = IDW'(40);
    @(negedge clk); eoi_valid = 1'b0;
    rd32(12'h304, d); chk("R10 eoi clears active", 64'(d), 64'h0);
    wr32(12'h304, 32'hFFFF_FFFF);
    rd32(12'h304, d); chk("R10 active write ignored", 64'(d), 64'h0);
  endtask

  task automatic t_forward;
    wr32(12'h104, 32'h0000_0001);
    wr32(12'h204, 32'h0000_0001);
    wr32(12'h000, 32'h0);
    chk("R11 blocked by ctrl", 64'(pend_out), 64'h0);
    wr32(12'h000, 32'h1);
    chk("R11 forwarded", 64'(pend_out), {32'h1, 32'h0});
    wr32(12'h184, 32'h0000_0001);
    chk("R11 blocked by enable", 64'(pend_out), 64'h0);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    wr32(12'h108, 32'hFFFF_FFFF);
    rd32(12'h108, d); chk("R12 group beyond range", 64'(d), 64'h0);
    wr32(12'h840, 32'hFFFF_FFFF);
    rd32(12'h840, d); chk("R12 target beyond range", 64'(d), 64'h0);
    rd32(12'hC10, d); chk("R12 config beyond range", 64'(d), 64'h0);
    rd32(12'h0F0, d); chk("R12 hole", 64'(d), 64'h0);
    wr32(12'h101, 32'hFFFF_FFFF);
    rd32(12'h101, d); chk("R12 misaligned read", 64'(d), 64'h0);
    rd32(12'h100, d); chk("R12 misaligned write ignored", 64'(d), 64'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_type();
    t_enable();
    t_edge();
    t_level();
    t_soft();
    t_prio_tgt_cfg();
    t_ack();
    t_forward();
    t_unimpl();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule